// File: doc/BRIEF.md
# Codec Register Write Sequencer

This block sits between a host-side register port and a three-wire serial control bus master that talks to an audio codec. The codec cannot be read back, so the block keeps a 14-entry, 8-bit shadow copy of every codec register. Host reads are served from this shadow. Each host write first updates the shadow. It is then turned into one or two bus transactions, depending on the register class. The serial master is driven through a request/done handshake, and each transaction carries an address byte and a data byte.

The bus address byte is built from a fixed device number and a two-bit type code. Extended registers do not have a bus address of their own. They are reached through the first data bank in two steps: one byte selects the extended index, and a second byte carries the value.

Two further host commands run longer sequences. The soft-reset command pulses the reset bit of the first status register, with a programmable wait between setting and clearing it. The replay command rewrites every shadow entry to the codec in ascending index order, for example after power is restored.

Top module: `codec_reg_seq`

## Requirements
- R1: After reset the shadow reads, for indices 0..13, 04,04,04,00,00,00,00,00,00,83,00,40,80,00 (hex). Reads of index 14 or 15 return 00. busy_o and l3_req_o are low.
- R2: Every transaction address byte is {6'd5, type}. The type is 0 for the first data bank, 1 for the second data bank and 2 for status, giving 8'h14, 8'h15 and 8'h16.
- R3: A write to index 8 or 9 issues one transaction (8'h16, value). A write to index 10, 11 or 12 issues one transaction (8'h14, value). A write to index 13 issues one transaction (8'h15, value).
- R4: A write to index 0..7 issues two transactions in order. The first is (8'h14, index | 8'hC0). The second is (8'h14, value | 8'hE0).
- R5: An accepted write updates the shadow at the acceptance edge. From the next cycle, rd_data_o shows the new value and busy_o is high, before any transfer completes.
- R6: A write with index 14 or 15 leaves the shadow unchanged, issues no transaction and keeps busy_o low. err_o pulses high for exactly one cycle on the cycle after the request.
- R7: While busy_o is high, host write requests are ignored. They change no shadow entry and issue no transaction.
- R8: Soft reset sets shadow entry 8 to its value with bit 6 set and sends it to 8'h16. It then waits at least RESET_WAIT_CYC cycles with no request. It then clears bit 6 in entry 8 and sends that value to 8'h16.
- R9: Replay sends shadow entries 0 through 13 in ascending order, each encoded as in R3 and R4, 22 transactions in total.
- R10: If l3_done_i does not arrive within L3_TIMEOUT cycles of a request, the request is withdrawn. err_o pulses for one cycle, and the whole operation is abandoned with busy_o low.
- R11: When more than one command is raised in the same idle cycle, soft reset wins over replay and replay wins over a write. The losing commands are dropped.
- R12: l3_req_o stays high with l3_addr_o and l3_data_o stable until l3_done_i or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_i | input | 1 | Host register write request |
| wr_idx_i | input | 4 | Register index of the write |
| wr_data_i | input | 8 | Value of the write |
| soft_rst_req_i | input | 1 | Start the codec soft-reset sequence |
| replay_req_i | input | 1 | Start rewriting every cached register |
| rd_idx_i | input | 4 | Shadow read index |
| rd_data_o | output | 8 | Shadow contents at rd_idx_i, combinational |
| busy_o | output | 1 | An operation is in progress |
| err_o | output | 1 | One-cycle error pulse (bad index or bus timeout) |
| l3_req_o | output | 1 | Transaction request to the serial master |
| l3_addr_o | output | 8 | Transaction address byte |
| l3_data_o | output | 8 | Transaction data byte |
| l3_done_i | input | 1 | Serial master reports the transaction finished |

## Verification
Writes are aimed at one index of every register class. Each class then shows a different address byte, and the extended indices show whether the two-step prefix encoding appears in the right order. Out-of-range indices, writes raised during a long transfer, and all three commands raised in one cycle separate the rejection, blocking and priority rules. Soft reset is checked by the gap measured between its two transfers. Replay follows earlier writes, so its 22 expected bytes come from the updated shadow and not from the reset contents. A slave that never answers exercises the timeout and the abandoning of the operation.

// File: rtl/codec_reg_pkg.sv
`timescale 1ns/1ps
package codec_reg_pkg;
  localparam int unsigned NUM_REGS = 14;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned DATA_W   = 8;

  localparam logic [5:0]        DEV_ADDR     = 6'd5;
  localparam logic [IDX_W-1:0]  LAST_IDX     = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0]  STATUS_IDX   = 4'd8;
  localparam logic [IDX_W-1:0]  FIRST_STATUS = 4'd8;
  localparam logic [IDX_W-1:0]  FIRST_BANK0  = 4'd10;
  localparam logic [IDX_W-1:0]  BANK1_IDX    = 4'd13;
  localparam logic [DATA_W-1:0] EXT_SEL_PFX  = 8'hC0;
  localparam logic [DATA_W-1:0] EXT_VAL_PFX  = 8'hE0;
  localparam int unsigned       SRST_BIT     = 6;

  typedef enum logic [1:0] {
    TYPE_BANK0  = 2'd0,
    TYPE_BANK1  = 2'd1,
    TYPE_STATUS = 2'd2
  } txn_type_e;

  typedef enum logic [1:0] {OP_WRITE, OP_SRST, OP_REPLAY} op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_BUSY, ST_WAIT} state_e;

  function automatic logic [DATA_W-1:0] reset_value(int unsigned idx);
    case (idx)
      0, 1, 2: reset_value = 8'h04;
      9:       reset_value = 8'h83;
      11:      reset_value = 8'h40;
      12:      reset_value = 8'h80;
      default: reset_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_shadow_cache.sv
`timescale 1ns/1ps
module codec_shadow_cache
  import codec_reg_pkg::*;
#(
  parameter int unsigned N  = NUM_REGS,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] w_idx_i,
  input  logic [DW-1:0] w_data_i,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o
);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= reset_value(i);
    end else if (we_i && w_idx_i <= TOP) begin
      mem_q[w_idx_i] <= w_data_i;
    end
  end

  assign ra_data_o = (ra_idx_i <= TOP) ? mem_q[ra_idx_i] : '0;
  assign rb_data_o = (rb_idx_i <= TOP) ? mem_q[rb_idx_i] : '0;
endmodule

// File: rtl/codec_txn_encoder.sv
`timescale 1ns/1ps
module codec_txn_encoder
  import codec_reg_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              second_i,
  output logic              is_ext_o,
  output logic [7:0]        addr_o,
  output logic [DATA_W-1:0] data_o
);
  txn_type_e ttype;

  assign is_ext_o = idx_i < FIRST_STATUS;

  always_comb begin
    if (idx_i >= BANK1_IDX)         ttype = TYPE_BANK1;
    else if (idx_i >= FIRST_BANK0)  ttype = TYPE_BANK0;
    else if (idx_i >= FIRST_STATUS) ttype = TYPE_STATUS;
    else                            ttype = TYPE_BANK0;
  end

  assign addr_o = {DEV_ADDR, ttype};

  always_comb begin
    if (!is_ext_o)     data_o = value_i;
    else if (second_i) data_o = value_i | EXT_VAL_PFX;
    else               data_o = {4'h0, idx_i} | EXT_SEL_PFX;
  end
endmodule

// File: rtl/codec_l3_issuer.sv
`timescale 1ns/1ps
module codec_l3_issuer #(
  parameter int unsigned TIMEOUT = 1024,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ok_o,
  output logic          fail_o,
  output logic          l3_req_o,
  output logic [AW-1:0] l3_addr_o,
  output logic [DW-1:0] l3_data_o,
  input  logic          l3_done_i
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic             req_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;

  assign ok_o   = req_q && l3_done_i;
  assign fail_o = req_q && !l3_done_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      req_q  <= 1'b1;
      cnt_q  <= '0;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (req_q) begin
      if (ok_o || fail_o) req_q <= 1'b0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign l3_req_o  = req_q;
  assign l3_addr_o = addr_q;
  assign l3_data_o = data_q;

  // R12: request and payload held until done or timeout
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l3_req_o && !l3_done_i && !fail_o) |=>
      (l3_req_o && $stable(l3_addr_o) && $stable(l3_data_o)));
endmodule

// File: rtl/codec_reg_seq.sv
`timescale 1ns/1ps
module codec_reg_seq
  import codec_reg_pkg::*;
#(
  parameter int unsigned RESET_WAIT_CYC = 200000,
  parameter int unsigned L3_TIMEOUT     = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              soft_rst_req_i,
  input  logic              replay_req_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              l3_req_o,
  output logic [7:0]        l3_addr_o,
  output logic [7:0]        l3_data_o,
  input  logic              l3_done_i
);
  localparam int unsigned WAIT_W = $clog2(RESET_WAIT_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(RESET_WAIT_CYC - 1);

  state_e            state_q;
  op_e               op_q;
  logic [IDX_W-1:0]  cur_idx_q;
  logic              second_q;
  logic              srst_step_q;
  logic [WAIT_W-1:0] wait_cnt_q;
  logic              err_q;

  logic              cw_en;
  logic [IDX_W-1:0]  cw_idx;
  logic [DATA_W-1:0] cw_data;
  logic [IDX_W-1:0]  int_idx;
  logic [DATA_W-1:0] int_data;
  logic              is_ext;
  logic [7:0]        enc_addr;
  logic [DATA_W-1:0] enc_data;
  logic              txn_ok, txn_fail;
  logic              wait_done;
  logic              host_valid;

  assign host_valid = wr_req_i && (wr_idx_i <= LAST_IDX);
  assign wait_done  = (state_q == ST_WAIT) && (wait_cnt_q == WAIT_LAST);
  assign int_idx    = (state_q == ST_IDLE) ? STATUS_IDX : cur_idx_q;

  always_comb begin
    cw_en   = 1'b0;
    cw_idx  = wr_idx_i;
    cw_data = wr_data_i;
    if (state_q == ST_IDLE) begin
      if (soft_rst_req_i) begin
        cw_en   = 1'b1;
        cw_idx  = STATUS_IDX;
        cw_data = int_data | DATA_W'(1 << SRST_BIT);
      end else if (!replay_req_i && host_valid) begin
        cw_en = 1'b1;
      end
    end else if (wait_done) begin
      cw_en   = 1'b1;
      cw_idx  = STATUS_IDX;
      cw_data = int_data & ~DATA_W'(1 << SRST_BIT);
    end
  end

  codec_shadow_cache #(.N(NUM_REGS), .IW(IDX_W), .DW(DATA_W)) i_cache (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cw_en),
    .w_idx_i   (cw_idx),
    .w_data_i  (cw_data),
    .ra_idx_i  (rd_idx_i),
    .ra_data_o (rd_data_o),
    .rb_idx_i  (int_idx),
    .rb_data_o (int_data)
  );

  codec_txn_encoder i_enc (
    .idx_i    (cur_idx_q),
    .value_i  (int_data),
    .second_i (second_q),
    .is_ext_o (is_ext),
    .addr_o   (enc_addr),
    .data_o   (enc_data)
  );

  codec_l3_issuer #(.TIMEOUT(L3_TIMEOUT), .AW(8), .DW(DATA_W)) i_issuer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state_q == ST_LAUNCH),
    .addr_i    (enc_addr),
    .data_i    (enc_data),
    .ok_o      (txn_ok),
    .fail_o    (txn_fail),
    .l3_req_o  (l3_req_o),
    .l3_addr_o (l3_addr_o),
    .l3_data_o (l3_data_o),
    .l3_done_i (l3_done_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_WRITE;
      cur_idx_q   <= '0;
      second_q    <= 1'b0;
      srst_step_q <= 1'b0;
      wait_cnt_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          second_q <= 1'b0;
          if (soft_rst_req_i) begin
            op_q        <= OP_SRST;
            cur_idx_q   <= STATUS_IDX;
            srst_step_q <= 1'b0;
            state_q     <= ST_LAUNCH;
          end else if (replay_req_i) begin
            op_q      <= OP_REPLAY;
            cur_idx_q <= '0;
            state_q   <= ST_LAUNCH;
          end else if (wr_req_i) begin
            if (host_valid) begin
              op_q      <= OP_WRITE;
              cur_idx_q <= wr_idx_i;
              state_q   <= ST_LAUNCH;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_LAUNCH: state_q <= ST_BUSY;
        ST_BUSY: begin
          if (txn_fail) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (txn_ok) begin
            if (is_ext && !second_q) begin
              second_q <= 1'b1;
              state_q  <= ST_LAUNCH;
            end else begin
              second_q <= 1'b0;
              unique case (op_q)
                OP_REPLAY: begin
                  if (cur_idx_q == LAST_IDX) state_q <= ST_IDLE;
                  else begin
                    cur_idx_q <= cur_idx_q + 1'b1;
                    state_q   <= ST_LAUNCH;
                  end
                end
                OP_SRST: begin
                  if (!srst_step_q) begin
                    wait_cnt_q <= '0;
                    state_q    <= ST_WAIT;
                  end else state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            srst_step_q <= 1'b1;
            state_q     <= ST_LAUNCH;
          end else wait_cnt_q <= wait_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign err_o  = err_q;

  p_addr_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l3_req_o |-> (l3_addr_o[7:2] == DEV_ADDR && l3_addr_o[1:0] != 2'd3));

  p_accept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !busy_o && wr_idx_i <= LAST_IDX) |=> busy_o);

  p_bad_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !busy_o && wr_idx_i > LAST_IDX && !soft_rst_req_i && !replay_req_i)
      |=> (!busy_o && err_o));

  p_wait_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !l3_req_o);

  p_timeout_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_fail |=> (err_o && !busy_o && !l3_req_o));

  p_srst_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_req_i && !busy_o) |=> (busy_o && op_q == OP_SRST));
endmodule

// File: tb/test_codec_reg_seq.sv
`timescale 1ns/1ps
module test_codec_reg_seq;
  localparam int unsigned WAIT_CYC = 40;
  localparam int unsigned TMO      = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       srst_req = 1'b0;
  logic       replay_req = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       busy, err, l3_req;
  logic [7:0] l3_addr, l3_data;
  logic       l3_done = 1'b0;

  always #2.5 clk = ~clk;

  codec_reg_seq #(.RESET_WAIT_CYC(WAIT_CYC), .L3_TIMEOUT(TMO)) i_codec_reg_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .soft_rst_req_i(srst_req), .replay_req_i(replay_req),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .busy_o(busy), .err_o(err),
    .l3_req_o(l3_req), .l3_addr_o(l3_addr), .l3_data_o(l3_data),
    .l3_done_i(l3_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  model [14] = '{8'h04, 8'h04, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00,
                              8'h00, 8'h00, 8'h83, 8'h00, 8'h40, 8'h80, 8'h00};

  int  cyc = 0, last_end = 0, gap = 0, err_seen = 0, slave_lat = 2, lat_cnt = 0;
  bit  seen = 0, mute = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // scoreboard monitor and serial-bus slave model
  always @(negedge clk) begin
    cyc++;
    if (err) err_seen++;
    l3_done <= 1'b0;
    if (rst_n) begin
      if (l3_req && !seen) begin
        seen = 1;
        gap = cyc - last_end;
        lat_cnt = slave_lat;
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected transaction", {l3_addr, l3_data}, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({l3_addr, l3_data} == e, t, {l3_addr, l3_data}, e);
        end
        if (!mute && lat_cnt <= 1) l3_done <= 1'b1;
      end else if (l3_req && seen) begin
        if (!mute) begin
          lat_cnt--;
          if (lat_cnt <= 1) l3_done <= 1'b1;
        end
      end else if (!l3_req && seen) begin
        seen = 0;
        last_end = cyc;
      end
    end
  end

  task automatic push(input logic [7:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  task automatic push_reg(input int i);
    if (i < 8) begin
      push(8'h14, 8'(i) | 8'hC0, "R4 ext select");
      push(8'h14, model[i] | 8'hE0, "R4 ext value");
    end else if (i < 10) push(8'h16, model[i], "R2 R3 status");
    else if (i < 13)    push(8'h14, model[i], "R2 R3 bank0");
    else                push(8'h15, model[i], "R2 R3 bank1");
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    rd_idx = i;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic host_write(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk);
    while (busy) @(negedge clk);
    wr_req = 1; wr_idx = i; wr_data = v;
    @(negedge clk);
    wr_req = 0;
  endtask

  task automatic write_reg(input int i, input logic [7:0] v);
    model[i] = v;
    push_reg(i);
    host_write(4'(i), v);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset contents
    for (int i = 0; i < 14; i++) begin
      rd(4'(i), v);
      chk(v == model[i], "R1 reset value", v, model[i]);
    end
    rd(4'd15, v);
    chk(v == 8'h00, "R1 out of range read", v, 0);
    chk(!busy && !l3_req, "R1 idle after reset", {busy, l3_req}, 0);

    // R5 shadow updated before transfer ends
    slave_lat = 6;
    model[9] = 8'h5A;
    push_reg(9);
    host_write(4'd9, 8'h5A);
    rd(4'd9, v);
    chk(v == 8'h5A, "R5 shadow early", v, 8'h5A);
    chk(busy == 1'b1, "R5 busy after accept", busy, 1);
    wait_idle();
    slave_lat = 2;

    // R2 R3 each class
    write_reg(11, 8'hC3);
    write_reg(13, 8'h27);
    write_reg(8, 8'h11);
    write_reg(10, 8'h3C);
    // R4 extended
    write_reg(2, 8'h1F);
    write_reg(5, 8'h03);
    write_reg(7, 8'hAA);

    // R6 invalid index
    e0 = err_seen;
    host_write(4'd14, 8'h77);
    chk(!busy, "R6 not busy", busy, 0);
    host_write(4'd15, 8'h77);
    wait_idle();
    chk(err_seen == e0 + 2, "R6 error pulses", err_seen - e0, 2);
    for (int i = 0; i < 14; i++) begin
      rd(4'(i), v);
      chk(v == model[i], "R6 shadow unchanged", v, model[i]);
    end

    // R7 write while busy is ignored
    slave_lat = 20;
    model[12] = 8'h66;
    push_reg(12);
    host_write(4'd12, 8'h66);
    repeat (2) @(negedge clk);
    wr_req = 1; wr_idx = 4'd11; wr_data = 8'h01;
    @(negedge clk);
    wr_req = 0;
    wait_idle();
    slave_lat = 2;
    rd(4'd11, v);
    chk(v == model[11], "R7 busy write ignored", v, model[11]);

    // R8 soft reset
    push(8'h16, model[8] | 8'h40, "R8 reset set");
    push(8'h16, model[8] & 8'hBF, "R8 reset clear");
    model[8] = model[8] & 8'hBF;
    @(negedge clk);
    srst_req = 1;
    @(negedge clk);
    srst_req = 0;
    rd(4'd8, v);
    chk(v == (model[8] | 8'h40), "R8 bit set in shadow", v, model[8] | 8'h40);
    wait_idle();
    chk(gap >= int'(WAIT_CYC), "R8 wait length", gap, WAIT_CYC);
    rd(4'd8, v);
    chk(v == model[8], "R8 bit cleared", v, model[8]);

    // R9 replay
    for (int i = 0; i < 14; i++) push_reg(i);
    @(negedge clk);
    replay_req = 1;
    @(negedge clk);
    replay_req = 0;
    wait_idle();

    // R11 priority
    push(8'h16, model[8] | 8'h40, "R11 reset wins set");
    push(8'h16, model[8] & 8'hBF, "R11 reset wins clear");
    @(negedge clk);
    srst_req = 1; replay_req = 1; wr_req = 1; wr_idx = 4'd10; wr_data = 8'h99;
    @(negedge clk);
    srst_req = 0; replay_req = 0; wr_req = 0;
    wait_idle();
    rd(4'd10, v);
    chk(v == model[10], "R11 write dropped", v, model[10]);

    // R10 timeout
    mute = 1;
    e0 = err_seen;
    model[10] = 8'h21;
    push_reg(10);
    host_write(4'd10, 8'h21);
    wait_idle();
    chk(err_seen == e0 + 1, "R10 timeout error", err_seen - e0, 1);
    chk(!busy && !l3_req, "R10 abandoned", {busy, l3_req}, 0);
    rd(4'd10, v);
    chk(v == 8'h21, "R10 shadow kept", v, 8'h21);
    mute = 0;
    write_reg(3, 8'h05);

    finish_run();
  end
endmodule